// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block produces the column address order for one DDR SDRAM read or write burst. A mode word, loaded by a strobe, sets the burst length (2, 4, 8 or 16 beats), the ordering (wrapped sequential or XOR interleaved) and the read latency. A word the block cannot honour is rejected and flagged, and the settings already loaded stay in force.

When a burst starts, the block takes the starting column and the read/write direction. It takes a snapshot of the current mode. After the latency it emits two column indices per clock, one for the rising-edge beat and one for the falling-edge beat. A one-cycle done pulse follows the last pair.

The beat output has a valid signal and no ready. Beats leave at the fixed pin rate, so the consumer has to take every pair in the cycle it is offered and cannot apply back-pressure.

Top module: `ddr_burst_colseq`

## Requirements
- R1: Bits [2:0] of the mode word select the burst length: code 1 gives 2 beats, code 2 gives 4, code 3 gives 8 and code 4 gives 16.
- R2: Bit 3 of the mode word selects the ordering: 0 is sequential and 1 is interleaved.
- R3: In sequential order, beat i has low bits (start + i) mod BL, which wraps inside the BL-aligned block. For example, BL 8 starting at 5 gives 5,6,7,0,1,2,3,4.
- R4: In interleaved order, beat i has low bits (start mod BL) XOR i. For example, BL 8 starting at 5 gives 5,4,7,6,1,0,3,2.
- R5: Only the low log2(BL) column bits change during a burst. All column bits above them keep their value from the start column.
- R6: Each valid cycle carries two beats, the even index on col_rise and the next index on col_fall, so a burst takes BL/2 valid cycles back to back.
- R7: The first pair of a write appears in the cycle after the start cycle. The first pair of a read appears 3 cycles after the start cycle. Bits [6:4] of the mode word must be 3.
- R8: burst_done is high for exactly one cycle, the cycle after the last pair. It is never high while a pair is valid.
- R9: cfg_error goes high, and the previous settings are kept, when a mode word has a length code outside 1..4, a latency field other than 3, or bit 7 set. A valid word clears cfg_error. cfg_error changes only on an accepted mode write.
- R10: In the cycle after an accepted mode write, start and mrs_strobe are both ignored.
- R11: An accepted start during an active burst drops the rest of that burst without a done pulse. The sequence then restarts from the new column.
- R12: After reset the mode is 2-beat sequential, no pair is valid, and done and cfg_error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrs_strobe | input | 1 | Load mode_word this cycle |
| mode_word | input | 8 | Mode word: [2:0] length code, [3] order, [6:4] latency, [7] test |
| start | input | 1 | Begin a burst |
| start_col | input | 9 | Starting column |
| start_rd | input | 1 | 1 for a read burst, 0 for a write burst |
| beat_valid | output | 1 | col_rise and col_fall hold a beat pair |
| col_rise | output | 9 | Column for the rising-edge beat |
| col_fall | output | 9 | Column for the falling-edge beat |
| burst_done | output | 1 | One-cycle pulse after the last pair |
| cfg_error | output | 1 | Last accepted mode word was rejected |

## Verification
The hardest cases to reach from the ports are restarts and commands that arrive in the cycle after a mode write.

- **Restarts:** a restart can only be observed while a 16-beat burst is partway through, and the abort must leave no done pulse behind. The stimulus issues a second start two pairs into a long write burst. It then checks that the new sequence begins in the very next cycle.
- **Mode-write window:** the stimulus raises start in the cycle directly after a mode write and confirms that no pair follows.
- **Ordering sweep:** every length, both orders and all 16 start offsets are swept, with varied upper column bits and a mix of reads and writes.

// File: rtl/ddr_colseq_pkg.sv
package ddr_colseq_pkg;

  typedef struct packed {
    logic [2:0] len_log;     // log2 of burst length, 1..4
    logic       interleave;  // 1: XOR order
  } burst_mode_t;

  localparam burst_mode_t MODE_RESET = '{len_log: 3'd1, interleave: 1'b0};

endpackage

// File: rtl/colseq_mode_reg.sv
module colseq_mode_reg
  import ddr_colseq_pkg::*;
#(
  parameter int MAX_LOG = 4,
  parameter int CL_SUP  = 3,
  parameter int MRD     = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mrs_strobe,
  input  logic [7:0]  mode_word,
  output burst_mode_t mode_o,
  output logic        cfg_error_o,
  output logic        busy_o
);
  localparam int BW = $clog2(MRD + 1);

  logic [BW-1:0] hold_cnt;
  logic          accept;
  logic          word_ok;

  assign busy_o  = (hold_cnt != '0);
  assign accept  = mrs_strobe && !busy_o;
  assign word_ok = (mode_word[2:0] != 3'd0) &&
                   (int'(mode_word[2:0]) <= MAX_LOG) &&
                   (int'(mode_word[6:4]) == CL_SUP) &&
                   !mode_word[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt    <= '0;
      mode_o      <= MODE_RESET;
      cfg_error_o <= 1'b0;
    end else if (accept) begin
      hold_cnt <= BW'(MRD - 1);
      if (word_ok) begin
        mode_o.len_log    <= mode_word[2:0];
        mode_o.interleave <= mode_word[3];
        cfg_error_o       <= 1'b0;
      end else begin
        cfg_error_o <= 1'b1;
      end
    end else if (busy_o) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/colseq_lat_cnt.sv
module colseq_lat_cnt #(
  parameter int LAT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LAT_W-1:0] load_val,
  output logic             expired
);
  logic [LAT_W-1:0] cnt;

  assign expired = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= load_val;
    else if (!expired) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/colseq_addr.sv
module colseq_addr #(
  parameter int COL_W = 9,
  parameter int IDX_W = 4
) (
  input  logic [COL_W-1:0] base,
  input  logic [2:0]       len_log,
  input  logic             interleave,
  input  logic [IDX_W-1:0] beat,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] seq_low;
  logic [COL_W-1:0] ilv_low;

  always_comb begin
    mask    = COL_W'((32'd1 << len_log) - 32'd1);
    seq_low = (base + COL_W'(beat)) & mask;
    ilv_low = (base ^ COL_W'(beat)) & mask;
    col     = (base & ~mask) | (interleave ? ilv_low : seq_low);
  end
endmodule

// File: rtl/ddr_burst_colseq.sv
module ddr_burst_colseq
  import ddr_colseq_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int MAX_LOG = 4,
  parameter int CL_SUP  = 3,
  parameter int MRD     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrs_strobe,
  input  logic [7:0]       mode_word,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_rd,
  output logic             beat_valid,
  output logic [COL_W-1:0] col_rise,
  output logic [COL_W-1:0] col_fall,
  output logic             burst_done,
  output logic             cfg_error
);
  localparam int IDX_W = MAX_LOG;
  localparam int LAT_W = $clog2(CL_SUP + 1);

  burst_mode_t      cur_mode;
  burst_mode_t      bmode;
  logic             mrs_busy;
  logic             start_ok;
  logic             active;
  logic             lat_done;
  logic [IDX_W-1:0] beat;
  logic [IDX_W:0]   beat_nxt;
  logic             last_pair;
  logic [COL_W-1:0] base_col;
  logic             done_q;
  logic [COL_W-1:0] col_pair [2];

  colseq_mode_reg #(.MAX_LOG(MAX_LOG), .CL_SUP(CL_SUP), .MRD(MRD)) u_mode (
    .clk(clk), .rst_n(rst_n), .mrs_strobe(mrs_strobe), .mode_word(mode_word),
    .mode_o(cur_mode), .cfg_error_o(cfg_error), .busy_o(mrs_busy)
  );

  assign start_ok = start && !mrs_busy;

  colseq_lat_cnt #(.LAT_W(LAT_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .load(start_ok),
    .load_val(start_rd ? LAT_W'(CL_SUP - 1) : '0),
    .expired(lat_done)
  );

  assign beat_valid = active && lat_done;
  assign beat_nxt   = {1'b0, beat} + (IDX_W+1)'(2);
  assign last_pair  = (beat_nxt == ((IDX_W+1)'(1) << bmode.len_log));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      beat     <= '0;
      base_col <= '0;
      bmode    <= MODE_RESET;
      done_q   <= 1'b0;
    end else begin
      done_q <= beat_valid && last_pair && !start_ok;
      if (start_ok) begin
        active   <= 1'b1;
        beat     <= '0;
        base_col <= start_col;
        bmode    <= cur_mode;
      end else if (beat_valid) begin
        beat <= beat_nxt[IDX_W-1:0];
        if (last_pair) active <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_edge
    colseq_addr #(.COL_W(COL_W), .IDX_W(IDX_W)) u_addr (
      .base(base_col), .len_log(bmode.len_log), .interleave(bmode.interleave),
      .beat(beat | IDX_W'(g)), .col(col_pair[g])
    );
  end

  assign col_rise   = col_pair[0];
  assign col_fall   = col_pair[1];
  assign burst_done = done_q;
endmodule

// File: rtl/colseq_chk.sv
module colseq_chk #(
  parameter int COL_W   = 9,
  parameter int MAX_LOG = 4,
  parameter int CL_SUP  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mrs_strobe,
  input logic [7:0]       mode_word,
  input logic             start,
  input logic             start_rd,
  input logic             busy,
  input logic             beat_valid,
  input logic [COL_W-1:0] col_rise,
  input logic [COL_W-1:0] col_fall,
  input logic             burst_done,
  input logic             cfg_error
);
  logic bad_word;
  assign bad_word = (mode_word[2:0] == 3'd0) || (int'(mode_word[2:0]) > MAX_LOG) ||
                    (int'(mode_word[6:4]) != CL_SUP) || mode_word[7];

  a_r7_write_next: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !start_rd |=> beat_valid);

  a_r7_read_waits: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && start_rd |=> !beat_valid);

  a_r8_done_follows_pair: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> !beat_valid && $past(beat_valid));

  a_r5_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (col_rise >> MAX_LOG) == (col_fall >> MAX_LOG));

  a_r6_pair_neighbours: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> col_rise[0] != col_fall[0]);

  a_r9_bad_word_flags: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_strobe && !busy && bad_word |=> cfg_error);

  a_r9_error_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !mrs_strobe |=> $stable(cfg_error));
endmodule

bind ddr_burst_colseq colseq_chk #(.COL_W(COL_W), .MAX_LOG(MAX_LOG), .CL_SUP(CL_SUP)) u_chk (
  .clk(clk), .rst_n(rst_n), .mrs_strobe(mrs_strobe), .mode_word(mode_word),
  .start(start), .start_rd(start_rd), .busy(mrs_busy), .beat_valid(beat_valid),
  .col_rise(col_rise), .col_fall(col_fall), .burst_done(burst_done),
  .cfg_error(cfg_error)
);

// File: tb/ddr_burst_colseq_tb.sv
module ddr_burst_colseq_tb;
  localparam int CL = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mrs_strobe = 1'b0;
  logic [7:0] mode_word = '0;
  logic       start = 1'b0;
  logic [8:0] start_col = '0;
  logic       start_rd = 1'b0;
  logic       beat_valid, burst_done, cfg_error;
  logic [8:0] col_rise, col_fall;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  ddr_burst_colseq u_dut (
    .clk(clk), .rst_n(rst_n), .mrs_strobe(mrs_strobe), .mode_word(mode_word),
    .start(start), .start_col(start_col), .start_rd(start_rd),
    .beat_valid(beat_valid), .col_rise(col_rise), .col_fall(col_fall),
    .burst_done(burst_done), .cfg_error(cfg_error)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R6 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  function automatic int mw(input int lg, input int ty, input int cl, input int tm);
    return (tm << 7) | (cl << 4) | (ty << 3) | lg;
  endfunction

  function automatic int exp_col(input int col, input int lg, input int ty, input int i);
    int m = (1 << lg) - 1;
    int low = ty ? (((col & m) ^ i) & m) : (((col & m) + i) & m);
    return (col & ~m & 9'h1ff) | low;
  endfunction

  task automatic load_mode(input int w);
    @(negedge clk); mrs_strobe = 1'b1; mode_word = w[7:0];
    @(negedge clk); mrs_strobe = 1'b0;
  endtask

  task automatic run_burst(input int col, input int lg, input int ty, input bit rd);
    int lat;
    string rq;
    lat = rd ? CL : 1;
    rq = ty ? "R4 R5" : "R3 R5";
    @(negedge clk); start = 1'b1; start_col = col[8:0]; start_rd = rd;
    @(negedge clk); start = 1'b0;
    for (int w = 1; w < lat; w++) begin
      chk(!beat_valid, "R7 read latency", beat_valid, 0);
      @(negedge clk);
    end
    for (int p = 0; p < (1 << lg) / 2; p++) begin
      chk(beat_valid, "R6 R7 pair valid", beat_valid, 1);
      chk(col_rise == exp_col(col, lg, ty, 2*p), rq, col_rise, exp_col(col, lg, ty, 2*p));
      chk(col_fall == exp_col(col, lg, ty, 2*p+1), rq, col_fall, exp_col(col, lg, ty, 2*p+1));
      chk(!burst_done, "R8 done early", burst_done, 0);
      @(negedge clk);
    end
    chk(!beat_valid, "R1 R6 burst length end", beat_valid, 0);
    chk(burst_done, "R8 done pulse", burst_done, 1);
    @(negedge clk);
    chk(!burst_done, "R8 done single", burst_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!beat_valid, "R12 reset valid", beat_valid, 0);
    chk(!burst_done, "R12 reset done", burst_done, 0);
    chk(!cfg_error, "R12 reset error", cfg_error, 0);
    rst_n = 1'b1;
    // R12: default 2-beat sequential
    run_burst(9'h0a7, 1, 0, 1'b0);
    run_burst(9'h0a6, 1, 0, 1'b1);

    // R1 R2 R3 R4 R5 R7: full sweep
    for (int lg = 1; lg <= 4; lg++) begin
      for (int ty = 0; ty < 2; ty++) begin
        load_mode(mw(lg, ty, CL, 0));
        chk(!cfg_error, "R9 valid word", cfg_error, 0);
        for (int off = 0; off < 16; off++) begin
          run_burst((((off * 37 + lg * 5) % 32) << 4) | off, lg, ty, (off % 3) == 0);
        end
      end
    end

    // R9: rejected words keep BL16 interleaved
    load_mode(mw(5, 0, CL, 0));
    chk(cfg_error, "R9 bad length code", cfg_error, 1);
    run_burst(9'h135, 4, 1, 1'b0);
    load_mode(mw(2, 0, 2, 0));
    chk(cfg_error, "R9 bad latency", cfg_error, 1);
    run_burst(9'h0c9, 4, 1, 1'b1);
    load_mode(mw(2, 0, CL, 1));
    chk(cfg_error, "R9 test bit", cfg_error, 1);
    run_burst(9'h1f0, 4, 1, 1'b0);
    load_mode(mw(2, 0, CL, 0));
    chk(!cfg_error, "R9 error cleared", cfg_error, 0);
    run_burst(9'h0ee, 2, 0, 1'b0);

    // R10: start right after a mode write is ignored
    load_mode(mw(3, 0, CL, 0));
    start = 1'b1; start_col = 9'h005; start_rd = 1'b0;
    @(negedge clk); start = 1'b0;
    chk(!beat_valid, "R10 start ignored", beat_valid, 0);
    @(negedge clk);
    chk(!beat_valid, "R10 start ignored", beat_valid, 0);
    // R10: a mode write right after one is ignored
    @(negedge clk); mrs_strobe = 1'b1; mode_word = mw(3, 0, CL, 0);
    @(negedge clk); mode_word = mw(7, 0, CL, 0);
    @(negedge clk); mrs_strobe = 1'b0;
    chk(!cfg_error, "R10 second mode write ignored", cfg_error, 0);
    run_burst(9'h005, 3, 0, 1'b0);

    // R11: restart in the middle of a 16-beat write
    load_mode(mw(4, 0, CL, 0));
    @(negedge clk); start = 1'b1; start_col = 9'h03c; start_rd = 1'b0;
    @(negedge clk); start = 1'b0;
    chk(col_rise == exp_col(9'h03c, 4, 0, 0), "R11 first burst", col_rise, exp_col(9'h03c, 4, 0, 0));
    @(negedge clk);
    chk(col_rise == exp_col(9'h03c, 4, 0, 2), "R11 first burst", col_rise, exp_col(9'h03c, 4, 0, 2));
    start = 1'b1; start_col = 9'h1a3;
    @(negedge clk); start = 1'b0;
    for (int p = 0; p < 8; p++) begin
      chk(beat_valid, "R11 restart valid", beat_valid, 1);
      chk(col_rise == exp_col(9'h1a3, 4, 0, 2*p), "R11 restart order", col_rise, exp_col(9'h1a3, 4, 0, 2*p));
      chk(col_fall == exp_col(9'h1a3, 4, 0, 2*p+1), "R11 restart order", col_fall, exp_col(9'h1a3, 4, 0, 2*p+1));
      chk(!burst_done, "R11 no done for aborted burst", burst_done, 0);
      @(negedge clk);
    end
    chk(burst_done, "R11 done after restarted burst", burst_done, 1);
    @(negedge clk);

    summary();
    $finish;
  end
endmodule